// File: doc/BRIEF.md
# Divided Countdown Interrupt Timer

This block is the countdown timer of a per-core interrupt controller. Software loads a start value and a divide setting. The block then counts down by one every prescaled step. When the count runs out it raises a pulse that the surrounding controller turns into an interrupt.

Each step lasts sixteen clock cycles times a divider of 1 to 128. The divider comes from a scattered three-bit code whose decoded power of two is rotated by one position. A free-running sixteen-cycle base period sets the step grid, and a new countdown always lines up with that grid. A mode input chooses between stopping at zero and reloading the start value. The current count is read back on a plain output.

The write port is a plain strobe with a selector and a data word. It has no ready and no back-pressure: a write is taken in the cycle its strobe is high, and it always completes. The count output and the expiry pulse are plain status pins.

Top module: `cdt_timer`

## Requirements
- R1: While reset is held and after it is released, before any write, `cur_count` is 0 and `expire` is 0.
- R2: A write with `wr_sel` = 0 stores `wr_data` as the start value and restarts the countdown from it. From the next cycle, `cur_count` shows the written value and any previous countdown is abandoned.
- R3: A write with `wr_sel` = 1 keeps only data bits 3, 1 and 0. Bit 2 and bits 31:4 are dropped. The code is {bit3, bit1, bit0}. The divider is 2 to the power ((code + 1) mod 8), so code 0 gives 2 and code 7 gives 1.
- R4: Once a countdown runs, `cur_count` drops by one every 16 × divider clock cycles.
- R5: Base periods end at every 16th clock edge after reset release. A countdown loaded between those edges waits for the next one before it starts timing a step. A countdown loaded on one of those edges starts at once. The first step therefore falls 16 × divider cycles after the first base boundary at or after the load edge.
- R6: The step that takes `cur_count` from 1 ends the countdown and raises `expire` for exactly one cycle. In one-shot mode (`periodic` = 0) `cur_count` then stays at 0.
- R7: With `periodic` = 1 at the ending step, `cur_count` is reloaded with the start value instead of 0, and counting goes on with the same step period.
- R8: A start value of 0 stops the timer. `cur_count` stays 0 and `expire` stays low.
- R9: A write with `wr_sel` = 2 (current count) or `wr_sel` = 3 changes nothing. `cur_count` and the timing are unaffected.
- R10: A divide write made while counting leaves the step in progress unchanged. It applies from the step after the next divider rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, taken in the cycle it is high |
| wr_sel | input | 2 | Target: 0 start value, 1 divide code, 2 current count (ignored), 3 none |
| wr_data | input | 32 | Write data |
| periodic | input | 1 | 1 reloads the start value on expiry, 0 stops at zero |
| cur_count | output | 32 | Current count in steps |
| expire | output | 1 | One-cycle pulse when a countdown ends |

## Verification
The checker watches, on every cycle, several relations:
- `expire` is a single-cycle pulse that only follows a count of 1.
- `cur_count` only holds or drops by one unless a start value is loaded or an expiry reloads it.
- A load shows its value in the next cycle.
- A zero count stays idle.

Timing needs the bench scenarios, because the step length depends on the decoded divider and on the phase of the load within the base period. Those scenarios are the expiry edge for each divide code, grid alignment for loads on and off a boundary, the delayed effect of a divide change, and periodic reload.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    SEL_INIT = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_CUR  = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  // scattered code: keep bits 3,1,0 of the written word
  function automatic logic [2:0] pack_code(input logic [31:0] d);
    return {d[3], d[1], d[0]};
  endfunction

  // rotated decode: shift amount is code+1 wrapping within three bits
  function automatic logic [2:0] code_to_shift(input logic [2:0] code);
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
  parameter int PRESCALE = 16,
  localparam int PRE_W = $clog2(PRESCALE)
) (
  input  logic clk,
  input  logic rst_n,
  output logic base_tick
);
  logic [PRE_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else if (phase_q == PRE_W'(PRESCALE - 1)) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  assign base_tick = (phase_q == PRE_W'(PRESCALE - 1));
endmodule

// File: rtl/cdt_divstage.sv
module cdt_divstage #(
  parameter int CODE_W = 3,
  localparam int DIVCNT_W = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              load,
  input  logic              run,
  input  logic [CODE_W-1:0] cfg_code,
  output logic              step
);
  import cdt_pkg::*;

  logic                pending_q;
  logic [DIVCNT_W-1:0] div_cnt_q;
  logic [CODE_W-1:0]   act_code_q;
  logic [DIVCNT_W-1:0] limit;
  logic [DIVCNT_W:0]   one_hot;

  always_comb begin
    one_hot = ({{DIVCNT_W{1'b0}}, 1'b1}) << code_to_shift(act_code_q);
    limit   = DIVCNT_W'(one_hot - 1'b1);
  end

  assign step = base_tick && run && !pending_q && !load && (div_cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q  <= 1'b0;
      div_cnt_q  <= '0;
      act_code_q <= '0;
    end else if (load) begin
      // a load on a boundary edge starts at once, otherwise wait for one
      pending_q  <= !base_tick;
      div_cnt_q  <= '0;
      act_code_q <= cfg_code;
    end else if (base_tick && run) begin
      if (pending_q) begin
        pending_q <= 1'b0;
      end else if (div_cnt_q == limit) begin
        div_cnt_q  <= '0;
        act_code_q <= cfg_code;
      end else begin
        div_cnt_q <= div_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cdt_countdown.sv
module cdt_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             periodic,
  output logic [CNT_W-1:0] count,
  output logic             run,
  output logic             expire
);
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] count_q;
  logic             expire_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= '0;
      count_q  <= '0;
      expire_q <= 1'b0;
    end else if (load) begin
      start_q  <= load_val;
      count_q  <= load_val;
      expire_q <= 1'b0;
    end else if (step) begin
      if (count_q == CNT_W'(1)) begin
        count_q  <= periodic ? start_q : '0;
        expire_q <= 1'b1;
      end else begin
        count_q  <= count_q - 1'b1;
        expire_q <= 1'b0;
      end
    end else begin
      expire_q <= 1'b0;
    end
  end

  assign count  = count_q;
  assign run    = (count_q != '0);
  assign expire = expire_q;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int CNT_W    = 32,
  parameter int PRESCALE = 16,
  parameter int CODE_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur_count,
  output logic             expire
);
  import cdt_pkg::*;

  logic              base_tick;
  logic              load;
  logic              cfg_wr;
  logic              step;
  logic              run;
  logic [CODE_W-1:0] cfg_code_q;

  assign load   = wr_en && (wsel_e'(wr_sel) == SEL_INIT);
  assign cfg_wr = wr_en && (wsel_e'(wr_sel) == SEL_DIV);

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_code_q <= '0;
    else if (cfg_wr) cfg_code_q <= CODE_W'(pack_code(wr_data));
  end

  cdt_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick)
  );

  cdt_divstage #(.CODE_W(CODE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .load(load),
    .run(run), .cfg_code(cfg_code_q), .step(step)
  );

  cdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(CNT_W'(wr_data)),
    .step(step), .periodic(periodic), .count(cur_count), .run(run),
    .expire(expire)
  );
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [31:0]      wr_data,
  input logic [CNT_W-1:0] cur_count,
  input logic             expire
);
  logic ld;
  assign ld = wr_en && (wr_sel == 2'd0);

  AST_EXPIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R6

  AST_EXPIRE_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expire) |-> ($past(cur_count) == CNT_W'(1))); // R6

  AST_LOAD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cur_count == $past(CNT_W'(wr_data)) && !expire)); // R2

  AST_COUNT_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (cur_count == $past(cur_count) ||
             cur_count == $past(cur_count) - CNT_W'(1) || expire)); // R4

  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_count == '0 && !ld) |=> (cur_count == '0 && !expire)); // R8

  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cur_count == '0 && !ld) |=> (cur_count == '0)); // R6
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .cur_count(cur_count), .expire(expire)
);

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 16;
  localparam int NVEC = 6;

  // {start value, divide write data, expected divider, periodic}
  typedef struct packed {
    logic [31:0] init;
    logic [31:0] cfg;
    logic [31:0] div;
    logic        per;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'd3, 32'h4, 32'd2,  1'b0},   // bit2 dropped -> code 0
    '{32'd5, 32'hF, 32'd1,  1'b1},   // code 7 -> 1
    '{32'd2, 32'h1, 32'd4,  1'b0},
    '{32'd1, 32'h2, 32'd8,  1'b1},
    '{32'd1, 32'h8, 32'd32, 1'b0},   // bit3 -> code 4
    '{32'd2, 32'h3, 32'd16, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        periodic = 1'b0;
  logic [31:0] cur_count;
  logic        expire;

  int edge_n = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edge_n <= 0;
    else edge_n <= edge_n + 1;
  end

  cdt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .periodic(periodic), .cur_count(cur_count),
    .expire(expire)
  );

  function automatic int nb(input int k);
    return ((k + BASE - 1) / BASE) * BASE;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  // called at a negedge; the write is taken at the next edge
  task automatic wr_now(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic wait_edge(input int e);
    while (edge_n < e) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", edge_n, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int kl, e, e2, s1;
    bit seen;
    repeat (4) @(negedge clk);
    chk(cur_count == 0, "R1 count in reset", cur_count, 0);
    chk(expire == 0, "R1 expire in reset", expire, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cur_count == 0, "R1 count after reset", cur_count, 0);
    chk(expire == 0, "R1 expire after reset", expire, 0);

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      periodic = VECS[i].per;
      @(negedge clk);
      wr_now(2'd1, VECS[i].cfg);
      wr_now(2'd0, VECS[i].init);
      kl = edge_n;
      chk(cur_count == VECS[i].init, "R2 load visible", cur_count, VECS[i].init);
      e = nb(kl) + BASE * int'(VECS[i].div) * int'(VECS[i].init);
      wait_edge(e - 1);
      chk(cur_count == 1 && !expire, "R4 count before expiry", cur_count, 1);
      wait_edge(e);
      chk(expire == 1, "R3 R5 expiry edge", expire, 1);
      if (VECS[i].per) begin
        chk(cur_count == VECS[i].init, "R7 reload", cur_count, VECS[i].init);
        wait_edge(e + 1);
        chk(expire == 0, "R6 single pulse", expire, 0);
        e2 = e + BASE * int'(VECS[i].div) * int'(VECS[i].init);
        wait_edge(e2 - 1);
        chk(expire == 0, "R7 before second expiry", expire, 1'b0);
        wait_edge(e2);
        chk(expire == 1 && cur_count == VECS[i].init, "R7 second expiry", cur_count, VECS[i].init);
        wr_now(2'd0, 32'd0);
        chk(cur_count == 0, "R8 stop", cur_count, 0);
      end else begin
        chk(cur_count == 0, "R6 one-shot zero", cur_count, 0);
        wait_edge(e + 1);
        chk(expire == 0, "R6 single pulse", expire, 0);
        wait_edge(e + 40);
        chk(cur_count == 0 && !expire, "R6 hold zero", cur_count, 0);
      end
    end
    periodic = 1'b0;

    // R5 alignment: load on a boundary edge, divider 1
    wr_now(2'd1, 32'hB);
    while (edge_n % BASE != BASE - 1) @(negedge clk);
    wr_now(2'd0, 32'd1);
    kl = edge_n;
    chk(kl % BASE == 0, "R5 load phase", kl % BASE, 0);
    wait_edge(kl + BASE - 1);
    chk(expire == 0, "R5 aligned early", expire, 0);
    wait_edge(kl + BASE);
    chk(expire == 1, "R5 aligned expiry", expire, 1);

    // R5 alignment: load just after a boundary
    while (edge_n % BASE != 0) @(negedge clk);
    wr_now(2'd0, 32'd1);
    kl = edge_n;
    wait_edge(nb(kl) + BASE - 1);
    chk(expire == 0, "R5 misaligned early", expire, 0);
    wait_edge(nb(kl) + BASE);
    chk(expire == 1, "R5 misaligned expiry", expire, 1);

    // R9 ignored writes to current count and unused selector
    @(negedge clk);
    wr_now(2'd0, 32'd9);
    kl = edge_n;
    wr_now(2'd2, 32'h55);
    chk(cur_count == 9, "R9 current-count write ignored", cur_count, 9);
    wr_now(2'd3, 32'h77);
    chk(cur_count == 9, "R9 unused selector ignored", cur_count, 9);
    wait_edge(nb(kl) + BASE * 9);
    chk(expire == 1, "R9 timing unchanged", expire, 1);

    // R2 restart mid-count
    @(negedge clk);
    wr_now(2'd0, 32'd5);
    wait_edge(edge_n + 40);
    wr_now(2'd0, 32'd2);
    kl = edge_n;
    chk(cur_count == 2, "R2 restart value", cur_count, 2);
    wait_edge(nb(kl) + BASE * 2);
    chk(expire == 1, "R2 restart expiry", expire, 1);

    // R10 divide change while counting
    @(negedge clk);
    wr_now(2'd1, 32'h0);
    wr_now(2'd0, 32'd3);
    kl = edge_n;
    s1 = nb(kl) + 2 * BASE;
    wait_edge(s1);
    chk(cur_count == 2, "R10 first step", cur_count, 2);
    wr_now(2'd1, 32'hB);
    wait_edge(s1 + 2 * BASE - 1);
    chk(cur_count == 2, "R10 old divider kept", cur_count, 2);
    wait_edge(s1 + 2 * BASE);
    chk(cur_count == 1, "R10 second step", cur_count, 1);
    wait_edge(s1 + 3 * BASE);
    chk(expire == 1, "R10 new divider used", expire, 1);

    // R8 zero start value
    @(negedge clk);
    wr_now(2'd0, 32'd0);
    seen = 1'b0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (expire || cur_count != 0) seen = 1'b1;
    end
    chk(!seen, "R8 zero stays idle", seen, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule